// File: doc/BRIEF.md
# PAL Composite Timing Generator

This block drives the two logic-level outputs of a resistor-ladder composite video stage for 625-line PAL monitors. One output selects the sync tip: low pulls the composite signal to 0 V, high holds it at the 0.3 V black level. The other output adds white when high. The block has no pixel store and no pixel input. Every frame it emits a vertical sync run followed by a fixed set of picture lines. Each picture line shows three vertical bars: white, black and white.

All timing is counted in cycles of a single 24 MHz clock. A line lasts 1536 cycles. A frame starts with five long pulses and then five short pulses, each one half a line (768 cycles). There is no trailing equalising group. The picture lines follow, 304 of them by default. Each picture line has a 96-cycle sync tip, a 192-cycle back porch and 1248 cycles of image in three 416-cycle bands. Any remainder of the line is padded at black. Two one-cycle strobes mark the start of each picture line and the start of each frame, so surrounding logic or a bench can align to the raster.

Top module: `pal_timing_gen`

## Requirements
- R1: While `rst_n` is low, `sync_o`=1, `video_o`=0 and both strobes are 0. In the first cycle after release, `frame_start_o`=1 and `sync_o`=0, so the frame restarts at its first long pulse.
- R2: Each picture line opens with `line_start_o`=1 for one cycle. In that same cycle `sync_o` drops low, and it stays low for exactly HSYNC_CYC (96) cycles.
- R3: Successive picture lines are exactly LINE_CYC (1536) cycles apart.
- R4: After the line sync, `sync_o`=1 and `video_o`=0 for exactly PORCH_CYC (192) cycles.
- R5: The image is three bands of BAND_CYC (416) cycles with `video_o` high, then low, then high. After the bands, the rest of the line (LINE_CYC − 1536 cycles, 0 by default) has `sync_o`=1 and `video_o`=0.
- R6: A frame starts with LONG_PULSES (5) long pulses. Each has `sync_o` low for 655 cycles and then high for LONG_HIGH_CYC (113) cycles.
- R7: Next come SHORT_PULSES (5) short pulses. Each has `sync_o` low for SHORT_LOW_CYC (56) cycles and then high for 712 cycles. The first picture line starts right after the last one.
- R8: Each frame holds PIC_LINES picture lines. A frame lasts 768·(LONG_PULSES+SHORT_PULSES) + 1536·PIC_LINES cycles.
- R9: `video_o` is 0 throughout both vertical pulse groups and whenever `sync_o` is 0.
- R10: The cycle after the last cycle of the last picture line carries `frame_start_o`=1, and a new long pulse begins there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 24 MHz timing clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| sync_o | output | 1 | Sync level: 0 = sync tip, 1 = black level |
| video_o | output | 1 | Luma: 1 = white, 0 = black |
| line_start_o | output | 1 | One-cycle strobe on the first cycle of each picture line |
| frame_start_o | output | 1 | One-cycle strobe on the first cycle of each frame |

## Verification
All four outputs are registered one cycle behind the internal position counters. After reset is released, `frame_start_o` and the first sync fall therefore appear at the first rising edge. The bench drives reset and samples every output at falling clock edges. It measures each result as the length of a run of constant levels, counted from the strobe or the level change that starts it. A fixed pipeline latency therefore cancels, and each width is compared with the exact cycle count in its requirement. The bench shortens the picture section to six lines so that it can measure whole frames and frame restarts.

// File: rtl/pal_tgen_pkg.sv
package pal_tgen_pkg;

  // Raster section currently being produced.
  typedef enum logic [1:0] {
    PH_LONG  = 2'd0,
    PH_SHORT = 2'd1,
    PH_PIC   = 2'd2
  } phase_e;

endpackage

// File: rtl/pal_tgen_hcount.sv
module pal_tgen_hcount #(
  parameter int LINE_CYC = 1536,
  localparam int HW      = $clog2(LINE_CYC)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [HW-1:0] h_o,
  output logic          half_end_o,
  output logic          line_end_o
);

  localparam logic [HW-1:0] LAST_C  = HW'(LINE_CYC - 1);
  localparam logic [HW-1:0] HLAST_C = HW'(LINE_CYC / 2 - 1);

  logic [HW-1:0] h_q, h_d;
  logic          h_en;
  logic          line_end, half_end;

  always_comb begin
    line_end = (h_q == LAST_C);
    half_end = line_end || (h_q == HLAST_C);
    h_en     = 1'b1;
    h_d      = line_end ? '0 : h_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    h_q <= '0;
    else if (h_en) h_q <= h_d;
  end

  assign h_o        = h_q;
  assign half_end_o = half_end;
  assign line_end_o = line_end;

  assert_h_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    h_q <= LAST_C);

  assert_h_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (h_q != '0) |-> (h_q == $past(h_q) + 1'b1));

endmodule

// File: rtl/pal_tgen_vseq.sv
module pal_tgen_vseq
  import pal_tgen_pkg::*;
#(
  parameter int LINE_CYC     = 1536,
  parameter int LONG_PULSES  = 5,
  parameter int SHORT_PULSES = 5,
  parameter int PIC_LINES    = 304,
  localparam int HW          = $clog2(LINE_CYC),
  localparam int MAXV        = (LONG_PULSES > SHORT_PULSES) ? LONG_PULSES : SHORT_PULSES,
  localparam int MAXC        = (PIC_LINES > MAXV) ? PIC_LINES : MAXV,
  localparam int CW          = $clog2(MAXC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] h_i,
  input  logic          half_end_i,
  input  logic          line_end_i,
  output phase_e        phase_o,
  output logic [CW-1:0] cnt_o
);

  localparam logic [CW-1:0] LONG_LAST_C  = CW'(LONG_PULSES - 1);
  localparam logic [CW-1:0] SHORT_LAST_C = CW'(SHORT_PULSES - 1);
  localparam logic [CW-1:0] PIC_LAST_C   = CW'(PIC_LINES - 1);

  phase_e        phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d, last_c;
  logic          adv_en, is_last;

  always_comb begin
    unique case (phase_q)
      PH_LONG:  last_c = LONG_LAST_C;
      PH_SHORT: last_c = SHORT_LAST_C;
      default:  last_c = PIC_LAST_C;
    endcase
    // Vertical groups advance per half-line, picture per full line.
    adv_en  = (phase_q == PH_PIC) ? line_end_i : half_end_i;
    is_last = (cnt_q == last_c);
    cnt_d   = is_last ? '0 : cnt_q + 1'b1;
    phase_d = phase_q;
    if (is_last) begin
      unique case (phase_q)
        PH_LONG:  phase_d = PH_SHORT;
        PH_SHORT: phase_d = PH_PIC;
        default:  phase_d = PH_LONG;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_LONG;
      cnt_q   <= '0;
    end else if (adv_en) begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign phase_o = phase_q;
  assign cnt_o   = cnt_q;

  assert_pic_on_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_PIC && $past(phase_q) != PH_PIC) |-> (h_i == '0));

  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last_c);

  assert_order_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase_q) == PH_PIC && phase_q != PH_PIC) |-> (phase_q == PH_LONG));

  assert_frame_top_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase_q) != PH_LONG && phase_q == PH_LONG) |-> (cnt_q == '0 && h_i == '0));

endmodule

// File: rtl/pal_tgen_wave.sv
module pal_tgen_wave
  import pal_tgen_pkg::*;
#(
  parameter int LINE_CYC      = 1536,
  parameter int HSYNC_CYC     = 96,
  parameter int PORCH_CYC     = 192,
  parameter int BAND_CYC      = 416,
  parameter int BANDS         = 3,
  parameter logic [BANDS-1:0] BAND_WHITE = 3'b101,
  parameter int LONG_HIGH_CYC = 113,
  parameter int SHORT_LOW_CYC = 56,
  parameter int CW            = 9,
  localparam int HW           = $clog2(LINE_CYC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  phase_e        phase_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [HW-1:0] h_i,
  output logic          sync_o,
  output logic          video_o,
  output logic          line_start_o,
  output logic          frame_start_o
);

  localparam logic [31:0] HALF_C      = 32'(LINE_CYC / 2);
  localparam logic [31:0] LONG_LOW_C  = 32'(LINE_CYC / 2 - LONG_HIGH_CYC);
  localparam logic [31:0] SHORT_LOW_C = 32'(SHORT_LOW_CYC);
  localparam logic [31:0] HSYNC_C     = 32'(HSYNC_CYC);
  localparam int          IMG0        = HSYNC_CYC + PORCH_CYC;

  logic [31:0]      hx, pos_half;
  logic [BANDS-1:0] band_hit;
  logic             sync_d, video_d, ls_d, fs_d;
  logic             sync_q, video_q, ls_q, fs_q;
  logic             out_en;

  assign hx = 32'(h_i);

  // One window comparator per picture band.
  for (genvar b = 0; b < BANDS; b++) begin : g_band
    localparam logic [31:0] LO_C = 32'(IMG0 + b * BAND_CYC);
    localparam logic [31:0] HI_C = 32'(IMG0 + (b + 1) * BAND_CYC);
    assign band_hit[b] = (hx >= LO_C) && (hx < HI_C);
  end

  always_comb begin
    pos_half = (hx >= HALF_C) ? hx - HALF_C : hx;
    sync_d   = 1'b1;
    video_d  = 1'b0;
    unique case (phase_i)
      PH_LONG:  sync_d = !(pos_half < LONG_LOW_C);
      PH_SHORT: sync_d = !(pos_half < SHORT_LOW_C);
      default: begin
        sync_d  = !(hx < HSYNC_C);
        video_d = |(band_hit & BAND_WHITE);
      end
    endcase
    ls_d   = (phase_i == PH_PIC)  && (h_i == '0);
    fs_d   = (phase_i == PH_LONG) && (cnt_i == '0) && (h_i == '0);
    out_en = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= 1'b1;
      video_q <= 1'b0;
      ls_q    <= 1'b0;
      fs_q    <= 1'b0;
    end else if (out_en) begin
      sync_q  <= sync_d;
      video_q <= video_d;
      ls_q    <= ls_d;
      fs_q    <= fs_d;
    end
  end

  assign sync_o        = sync_q;
  assign video_o       = video_q;
  assign line_start_o  = ls_q;
  assign frame_start_o = fs_q;

  assert_black_in_sync_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_q |-> !video_q);

  assert_line_opens_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ls_q |-> !sync_q);

  assert_frame_opens_long_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fs_q |-> (!sync_q && !ls_q));

  assert_vert_black_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i != PH_PIC) |=> !video_q);

endmodule

// File: rtl/pal_timing_gen.sv
module pal_timing_gen
  import pal_tgen_pkg::*;
#(
  parameter int LINE_CYC      = 1536,
  parameter int HSYNC_CYC     = 96,
  parameter int PORCH_CYC     = 192,
  parameter int BAND_CYC      = 416,
  parameter int LONG_HIGH_CYC = 113,
  parameter int SHORT_LOW_CYC = 56,
  parameter int LONG_PULSES   = 5,
  parameter int SHORT_PULSES  = 5,
  parameter int PIC_LINES     = 304,
  localparam int HW           = $clog2(LINE_CYC),
  localparam int MAXV         = (LONG_PULSES > SHORT_PULSES) ? LONG_PULSES : SHORT_PULSES,
  localparam int MAXC         = (PIC_LINES > MAXV) ? PIC_LINES : MAXV,
  localparam int CW           = $clog2(MAXC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  output logic sync_o,
  output logic video_o,
  output logic line_start_o,
  output logic frame_start_o
);

  logic [HW-1:0] h;
  logic          half_end, line_end;
  phase_e        phase;
  logic [CW-1:0] cnt;

  pal_tgen_hcount #(
    .LINE_CYC (LINE_CYC)
  ) i_hcount (
    .clk        (clk),
    .rst_n      (rst_n),
    .h_o        (h),
    .half_end_o (half_end),
    .line_end_o (line_end)
  );

  pal_tgen_vseq #(
    .LINE_CYC     (LINE_CYC),
    .LONG_PULSES  (LONG_PULSES),
    .SHORT_PULSES (SHORT_PULSES),
    .PIC_LINES    (PIC_LINES)
  ) i_vseq (
    .clk        (clk),
    .rst_n      (rst_n),
    .h_i        (h),
    .half_end_i (half_end),
    .line_end_i (line_end),
    .phase_o    (phase),
    .cnt_o      (cnt)
  );

  pal_tgen_wave #(
    .LINE_CYC      (LINE_CYC),
    .HSYNC_CYC     (HSYNC_CYC),
    .PORCH_CYC     (PORCH_CYC),
    .BAND_CYC      (BAND_CYC),
    .BANDS         (3),
    .BAND_WHITE    (3'b101),
    .LONG_HIGH_CYC (LONG_HIGH_CYC),
    .SHORT_LOW_CYC (SHORT_LOW_CYC),
    .CW            (CW)
  ) i_wave (
    .clk           (clk),
    .rst_n         (rst_n),
    .phase_i       (phase),
    .cnt_i         (cnt),
    .h_i           (h),
    .sync_o        (sync_o),
    .video_o       (video_o),
    .line_start_o  (line_start_o),
    .frame_start_o (frame_start_o)
  );

endmodule

// File: tb/test_pal_timing_gen.sv
`timescale 1ns/1ps
module test_pal_timing_gen;

  localparam int LINES = 6;
  localparam int LINE  = 1536;
  localparam int HALF  = LINE / 2;
  localparam int FRAME = 10 * HALF + LINES * LINE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_o, video_o, line_start_o, frame_start_o;
  int   n_tests = 0;
  int   n_fail  = 0;

  always #2.5 clk = ~clk;

  pal_timing_gen #(.PIC_LINES(LINES)) i_pal_timing_gen (
    .clk           (clk),
    .rst_n         (rst_n),
    .sync_o        (sync_o),
    .video_o       (video_o),
    .line_start_o  (line_start_o),
    .frame_start_o (frame_start_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Count falling edges while sync keeps level lvl; flag any white seen.
  task automatic run_sync(input logic lvl, output int n, output bit white);
    n = 0; white = 0;
    while (sync_o == lvl) begin
      if (video_o) white = 1;
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    check(sync_o && !video_o && !line_start_o && !frame_start_o, "R1",
          "idle outputs in reset", {sync_o, video_o, line_start_o, frame_start_o}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    check(frame_start_o && !sync_o, "R1", "frame start after release",
          {frame_start_o, sync_o}, 2'b10);
  endtask

  // Entered on the frame_start cycle.
  task automatic t_vertical;
    int n; bit w; bit anyw = 0;
    for (int p = 0; p < 10; p++) begin
      run_sync(1'b0, n, w); anyw |= w;
      if (p < 5) check(n == HALF - 113, "R6", "long pulse low", n, HALF - 113);
      else       check(n == 56, "R7", "short pulse low", n, 56);
      run_sync(1'b1, n, w); anyw |= w;
      if (p < 5) check(n == 113, "R6", "long pulse high", n, 113);
      else       check(n == HALF - 56, "R7", "short pulse high", n, HALF - 56);
    end
    check(!anyw, "R9", "white during vertical groups", anyw, 0);
    check(line_start_o, "R7", "picture follows short pulses", line_start_o, 1);
  endtask

  // Entered on a line_start cycle.
  task automatic t_line(input int idx);
    int n, tot; bit w;
    run_sync(1'b0, n, w); tot = n;
    check(n == 96, "R2", $sformatf("line %0d sync width", idx), n, 96);
    check(!w, "R9", "white during line sync", w, 0);
    n = 0;
    while (sync_o && !video_o) begin n++; @(negedge clk); end
    tot += n;
    check(n == 192, "R4", "back porch", n, 192);
    n = 0; while (video_o) begin n++; @(negedge clk); end
    tot += n;
    check(n == 416, "R5", "band 1 white", n, 416);
    n = 0; while (!video_o && sync_o) begin n++; @(negedge clk); end
    tot += n;
    check(n == 416, "R5", "band 2 black", n, 416);
    n = 0; while (video_o) begin n++; @(negedge clk); end
    tot += n;
    check(n == 416, "R5", "band 3 white", n, 416);
    n = 0;
    while (!line_start_o && !frame_start_o) begin
      if (!sync_o || video_o) n += 10000;
      n++; @(negedge clk);
    end
    tot += n;
    check(n == 0, "R5", "black padding", n, 0);
    check(tot == LINE, "R3", "line period", tot, LINE);
  endtask

  task automatic t_picture;
    int got = 0;
    while (line_start_o) begin
      t_line(got);
      got++;
    end
    check(got == LINES, "R8", "picture lines per frame", got, LINES);
    check(frame_start_o && !sync_o, "R10", "frame restart after last line",
          {frame_start_o, sync_o}, 2'b10);
  endtask

  task automatic t_frame_period;
    int n = 1;
    @(negedge clk);
    while (!frame_start_o) begin n++; @(negedge clk); end
    check(n == FRAME, "R8", "frame period", n, FRAME);
  endtask

  task automatic t_mid_reset;
    repeat (2) begin
      @(negedge clk);
      while (!line_start_o) @(negedge clk);
    end
    repeat (300) @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(sync_o && !video_o && !line_start_o && !frame_start_o, "R1",
          "mid-frame reset idles outputs", {sync_o, video_o, line_start_o, frame_start_o}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    check(frame_start_o && !sync_o, "R1", "restart at long pulse",
          {frame_start_o, sync_o}, 2'b10);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_vertical();
        t_picture();
        t_frame_period();
        t_mid_reset();
        t_vertical();
      end
      begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL R10 watchdog: actual %0d cycles expected completion", 200000);
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule